// File: doc/BRIEF.md
# TFT Display Sync Timing Generator

This block produces the raster timing for a parallel RGB panel. It divides an internal clock into a pixel clock, then runs a horizontal pixel counter and a vertical line counter. From those two counters it derives the horizontal sync, vertical sync and data-enable strobes. It also drives a panel chip select and gates the RGB data from a frame-buffer fetch unit. While the data-enable strobe is active, the block gives that fetch unit the pixel's column and row inside the visible area.

Every timing quantity is a static input: the visible width and height, the front and back porches, the sync pulse widths, the pixel clock period, a start delay, and the RGB setup and hold windows. Each pin has its own polarity bit. The configuration inputs may change only while the drive enable is low. Raising the drive enable starts scanning from the top-left of a frame. Lowering it returns every pin to its idle level.

Top module: `tft_sync_gen`

## Requirements
- R1: While reset is asserted, every sync, enable, clock and select pin sits at its inactive level, `rgb_o` is zero and both coordinates are zero.
- R2: The pixel clock period P in internal cycles equals `dclk_period`, except that values 0 and 1 give P = 2. Inside each period the phase runs from 0 to P-1. `dclk_o` is inactive for phases below P/2 (rounded down) and active from phase P/2, which is the active edge.
- R3: Once the drive enable is sampled high, the first pixel period begins after `start_pos`+1 rising edges. Until then, dclk, hsync, vsync and data-enable stay inactive and the chip select is already active.
- R4: A line is made of four parts in this order: `h_sync_m1`+1 sync pixels, `h_back` back-porch pixels, `h_size_m1`+1 visible pixels and `h_front` front-porch pixels. The column advances at the end of every pixel period. `hsync_o` is active only during the sync part.
- R5: A frame is built in lines in the same order: `v_sync_m1`+1 sync lines, `v_back` lines, `v_size_m1`+1 visible lines and `v_front` lines. The row advances after the last pixel of each line. `vsync_o` is active only during the sync lines.
- R6: `de_o` is active exactly when the column and the row are both inside their visible parts.
- R7: While `de_o` is active, `h_coord_o` and `v_coord_o` give the zero-based index within the visible area. Otherwise both are zero.
- R8: `rgb_o` equals `rgb_in` during a visible pixel at phases from P/2-`data_setup` through P/2+`data_hold`. The lower bound stops at phase 0 and the upper bound at phase P-1. `rgb_o` is zero at all other times.
- R9: `pol_sel` sets the active level of each pin, where 1 means active-high and 0 means active-low. The bits are [0] hsync, [1] vsync, [2] data-enable, [3] pixel clock and [4] chip select.
- R10: If the drive enable is low at a rising edge, every pin is inactive after that edge and `rgb_o` is zero. A later enable restarts scanning from column 0, row 0, phase 0.
- R11: A visible width of 1024 (`h_size_m1` = 1023) is scanned in full, and the last visible column reports coordinate 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drive_en | input | 1 | Starts scanning when high, idles the panel when low |
| dclk_period | input | 11 | Pixel clock period in internal cycles |
| start_pos | input | 11 | Delay before the first pixel period |
| h_size_m1 | input | 10 | Visible width minus one |
| v_size_m1 | input | 10 | Visible height minus one |
| h_front | input | 8 | Horizontal front porch in pixels |
| h_back | input | 8 | Horizontal back porch in pixels |
| v_front | input | 8 | Vertical front porch in lines |
| v_back | input | 8 | Vertical back porch in lines |
| h_sync_m1 | input | 7 | Horizontal sync width minus one |
| v_sync_m1 | input | 7 | Vertical sync width minus one |
| data_setup | input | 2 | RGB drive cycles before the active edge |
| data_hold | input | 2 | RGB hold cycles after the active edge |
| pol_sel | input | 5 | Per-pin active level |
| rgb_in | input | 16 | Pixel data from the fetch unit |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data-enable pin |
| dclk_o | output | 1 | Pixel clock pin |
| cs_o | output | 1 | Panel chip select pin |
| rgb_o | output | 16 | Gated RGB data |
| h_coord_o | output | 10 | Visible column for the fetch unit |
| v_coord_o | output | 10 | Visible row for the fetch unit |

## Verification
The bench builds the block with its default widths: 11-bit clock and start fields, 10-bit size fields, 8-bit porches, 7-bit sync widths and 16-bit RGB. Random configurations use small sizes, porches and periods, so that each run covers several lines and frame wraps in a few hundred cycles. The full 10-bit size field stays reachable: a directed case with one-pixel porches replaced by zero porches and a period of 2 sweeps a 1024-pixel line to its last coordinate. Directed cases also cover periods 0 and 1, odd periods, setup and hold windows that reach past the period ends, and re-enabling after a single idle cycle.

// File: rtl/tft_sync_pkg.sv
package tft_sync_pkg;

    // Bit positions inside the polarity select input
    localparam int POL_HS = 0;
    localparam int POL_VS = 1;
    localparam int POL_DE = 2;
    localparam int POL_CK = 3;
    localparam int POL_CS = 4;
    localparam int NPOL   = 5;

    // Part of a line or a frame that a scan counter is in
    typedef enum logic [1:0] {
        SEG_SYNC  = 2'd0,
        SEG_BACK  = 2'd1,
        SEG_VIS   = 2'd2,
        SEG_FRONT = 2'd3
    } scan_seg_e;

endpackage

// File: rtl/tft_dclk_gen.sv
module tft_dclk_gen #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drive_en,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] start,
    output logic          armed,
    output logic          running,
    output logic          dclk_act,
    output logic          pix_end,
    output logic [CW-1:0] phase,
    output logic [CW-1:0] half
);

    typedef struct packed {
        logic          armed;
        logic          run;
        logic [CW-1:0] wait_cnt;
        logic [CW-1:0] ph;
    } dclk_st_t;

    dclk_st_t      st_d, st_q;
    logic [CW-1:0] per_eff;
    logic [CW-1:0] last_ph;

    always_comb begin
        per_eff = (period < CW'(2)) ? CW'(2) : period;
        half    = per_eff >> 1;
        last_ph = per_eff - CW'(1);

        st_d = st_q;
        if (!drive_en) begin
            st_d = '0;
        end else begin
            st_d.armed = 1'b1;
            if (!st_q.run) begin
                if (st_q.wait_cnt == start) begin
                    st_d.run = 1'b1;
                    st_d.ph  = '0;
                end else begin
                    st_d.wait_cnt = st_q.wait_cnt + CW'(1);
                end
            end else begin
                st_d.ph = (st_q.ph == last_ph) ? '0 : st_q.ph + CW'(1);
            end
        end

        armed    = st_q.armed;
        running  = st_q.run;
        phase    = st_q.ph;
        dclk_act = st_q.run && (st_q.ph >= half);
        pix_end  = st_q.run && (st_q.ph == last_ph);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tft_scan_axis.sv
module tft_scan_axis
    import tft_sync_pkg::*;
#(
    parameter int SZW = 10,
    parameter int PW  = 8,
    parameter int SWW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           step,
    input  logic [SZW-1:0] size_m1,
    input  logic [PW-1:0]  back,
    input  logic [PW-1:0]  front,
    input  logic [SWW-1:0] sync_m1,
    output logic           in_sync,
    output logic           in_vis,
    output logic [SZW-1:0] coord,
    output logic           wrap
);

    localparam int POSW = $clog2((1 << SWW) + (1 << SZW) + 2 * (1 << PW));

    typedef struct packed {
        logic [POSW-1:0] pos;
    } axis_st_t;

    axis_st_t        st_d, st_q;
    logic [POSW-1:0] sync_end, vis_beg, vis_end, last_pos;
    scan_seg_e       seg;

    always_comb begin
        sync_end = POSW'(sync_m1) + POSW'(1);
        vis_beg  = sync_end + POSW'(back);
        vis_end  = vis_beg + POSW'(size_m1) + POSW'(1);
        last_pos = vis_end + POSW'(front) - POSW'(1);

        if (st_q.pos < sync_end)     seg = SEG_SYNC;
        else if (st_q.pos < vis_beg) seg = SEG_BACK;
        else if (st_q.pos < vis_end) seg = SEG_VIS;
        else                         seg = SEG_FRONT;

        wrap = step && (st_q.pos == last_pos);

        st_d = st_q;
        if (clr)       st_d.pos = '0;
        else if (wrap) st_d.pos = '0;
        else if (step) st_d.pos = st_q.pos + POSW'(1);

        in_sync = (seg == SEG_SYNC);
        in_vis  = (seg == SEG_VIS);
        coord   = in_vis ? SZW'(st_q.pos - vis_beg) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tft_pin_drive.sv
module tft_pin_drive
    import tft_sync_pkg::*;
#(
    parameter int CW  = 11,
    parameter int SHW = 2,
    parameter int DW  = 16,
    parameter int SZW = 10
) (
    input  logic            armed,
    input  logic            running,
    input  logic            h_sync,
    input  logic            v_sync,
    input  logic            h_vis,
    input  logic            v_vis,
    input  logic            dclk_act,
    input  logic [SZW-1:0]  h_coord,
    input  logic [SZW-1:0]  v_coord,
    input  logic [CW-1:0]   phase,
    input  logic [CW-1:0]   half,
    input  logic [SHW-1:0]  setup,
    input  logic [SHW-1:0]  hold,
    input  logic [NPOL-1:0] pol,
    input  logic [DW-1:0]   rgb_in,
    output logic [NPOL-1:0] pins,
    output logic [DW-1:0]   rgb_out,
    output logic [SZW-1:0]  h_coord_out,
    output logic [SZW-1:0]  v_coord_out
);

    logic [NPOL-1:0] act_v;
    logic            de_act;
    logic            in_win;
    logic [CW:0]     ph_lead;
    logic [CW:0]     win_hi;

    always_comb begin
        de_act = running && h_vis && v_vis;
        ph_lead = {1'b0, phase} + (CW + 1)'(setup);
        win_hi  = {1'b0, half} + (CW + 1)'(hold);
        in_win  = (ph_lead >= {1'b0, half}) && ({1'b0, phase} <= win_hi);

        act_v         = '0;
        act_v[POL_HS] = running && h_sync;
        act_v[POL_VS] = running && v_sync;
        act_v[POL_DE] = de_act;
        act_v[POL_CK] = dclk_act;
        act_v[POL_CS] = armed;

        rgb_out     = (de_act && in_win) ? rgb_in : '0;
        h_coord_out = de_act ? h_coord : '0;
        v_coord_out = de_act ? v_coord : '0;
    end

    // Each pin shows its polarity bit when active, its inverse when idle
    for (genvar i = 0; i < NPOL; i++) begin : g_pol
        assign pins[i] = ~(act_v[i] ^ pol[i]);
    end

endmodule

// File: rtl/tft_sync_gen.sv
module tft_sync_gen
    import tft_sync_pkg::*;
#(
    parameter int CW  = 11,
    parameter int SZW = 10,
    parameter int PW  = 8,
    parameter int SWW = 7,
    parameter int SHW = 2,
    parameter int DW  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            drive_en,
    input  logic [CW-1:0]   dclk_period,
    input  logic [CW-1:0]   start_pos,
    input  logic [SZW-1:0]  h_size_m1,
    input  logic [SZW-1:0]  v_size_m1,
    input  logic [PW-1:0]   h_front,
    input  logic [PW-1:0]   h_back,
    input  logic [PW-1:0]   v_front,
    input  logic [PW-1:0]   v_back,
    input  logic [SWW-1:0]  h_sync_m1,
    input  logic [SWW-1:0]  v_sync_m1,
    input  logic [SHW-1:0]  data_setup,
    input  logic [SHW-1:0]  data_hold,
    input  logic [NPOL-1:0] pol_sel,
    input  logic [DW-1:0]   rgb_in,
    output logic            hsync_o,
    output logic            vsync_o,
    output logic            de_o,
    output logic            dclk_o,
    output logic            cs_o,
    output logic [DW-1:0]   rgb_o,
    output logic [SZW-1:0]  h_coord_o,
    output logic [SZW-1:0]  v_coord_o
);

    logic            armed, running, dclk_act, pix_end;
    logic [CW-1:0]   phase, half;
    logic            h_sync, h_vis, h_wrap;
    logic            v_sync, v_vis, v_wrap;
    logic [SZW-1:0]  h_coord, v_coord;
    logic [NPOL-1:0] pins;

    tft_dclk_gen #(.CW(CW)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .drive_en (drive_en),
        .period   (dclk_period),
        .start    (start_pos),
        .armed    (armed),
        .running  (running),
        .dclk_act (dclk_act),
        .pix_end  (pix_end),
        .phase    (phase),
        .half     (half)
    );

    tft_scan_axis #(.SZW(SZW), .PW(PW), .SWW(SWW)) u_hax (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!running),
        .step    (pix_end),
        .size_m1 (h_size_m1),
        .back    (h_back),
        .front   (h_front),
        .sync_m1 (h_sync_m1),
        .in_sync (h_sync),
        .in_vis  (h_vis),
        .coord   (h_coord),
        .wrap    (h_wrap)
    );

    tft_scan_axis #(.SZW(SZW), .PW(PW), .SWW(SWW)) u_vax (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!running),
        .step    (h_wrap),
        .size_m1 (v_size_m1),
        .back    (v_back),
        .front   (v_front),
        .sync_m1 (v_sync_m1),
        .in_sync (v_sync),
        .in_vis  (v_vis),
        .coord   (v_coord),
        .wrap    (v_wrap)
    );

    tft_pin_drive #(.CW(CW), .SHW(SHW), .DW(DW), .SZW(SZW)) u_pins (
        .armed       (armed),
        .running     (running),
        .h_sync      (h_sync),
        .v_sync      (v_sync),
        .h_vis       (h_vis),
        .v_vis       (v_vis),
        .dclk_act    (dclk_act),
        .h_coord     (h_coord),
        .v_coord     (v_coord),
        .phase       (phase),
        .half        (half),
        .setup       (data_setup),
        .hold        (data_hold),
        .pol         (pol_sel),
        .rgb_in      (rgb_in),
        .pins        (pins),
        .rgb_out     (rgb_o),
        .h_coord_out (h_coord_o),
        .v_coord_out (v_coord_o)
    );

    // A frame wrap needs no action: the vertical counter reloads itself
    logic frame_wrap_unused;
    assign frame_wrap_unused = v_wrap;

    assign hsync_o = pins[POL_HS];
    assign vsync_o = pins[POL_VS];
    assign de_o    = pins[POL_DE];
    assign dclk_o  = pins[POL_CK];
    assign cs_o    = pins[POL_CS];

endmodule

// File: rtl/tft_sync_chk.sv
module tft_sync_chk #(
    parameter int CW  = 11,
    parameter int SZW = 10,
    parameter int DW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           drive_en,
    input logic [4:0]     pol_sel,
    input logic           hsync_o,
    input logic           vsync_o,
    input logic           de_o,
    input logic           dclk_o,
    input logic           cs_o,
    input logic [DW-1:0]  rgb_o,
    input logic [SZW-1:0] h_coord_o,
    input logic [SZW-1:0] v_coord_o,
    input logic           running,
    input logic [CW-1:0]  phase
);

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |=> (hsync_o == !pol_sel[0] && vsync_o == !pol_sel[1] &&
                       de_o == !pol_sel[2] && dclk_o == !pol_sel[3] &&
                       cs_o == !pol_sel[4] && rgb_o == '0)); // R10

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && drive_en) |=> (phase == '0 || phase == CW'($past(phase) + 1'b1))); // R2

    AST_DCLK_HELD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (dclk_o == !pol_sel[3] && de_o == !pol_sel[2])); // R3

    AST_DE_NOT_IN_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (de_o == pol_sel[2]) |-> (hsync_o == !pol_sel[0] && vsync_o == !pol_sel[1])); // R6

    AST_RGB_IN_DE: assert property (@(posedge clk) disable iff (!rst_n)
        (rgb_o != '0) |-> (de_o == pol_sel[2])); // R8

    AST_COORD_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (de_o != pol_sel[2]) |-> (h_coord_o == '0 && v_coord_o == '0)); // R7

endmodule

bind tft_sync_gen tft_sync_chk #(.CW(CW), .SZW(SZW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drive_en  (drive_en),
    .pol_sel   (pol_sel),
    .hsync_o   (hsync_o),
    .vsync_o   (vsync_o),
    .de_o      (de_o),
    .dclk_o    (dclk_o),
    .cs_o      (cs_o),
    .rgb_o     (rgb_o),
    .h_coord_o (h_coord_o),
    .v_coord_o (v_coord_o),
    .running   (running),
    .phase     (phase)
);

// File: tb/sim_tft_sync_gen.sv
module sim_tft_sync_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        drive_en;
    logic [10:0] dclk_period, start_pos;
    logic [9:0]  h_size_m1, v_size_m1;
    logic [7:0]  h_front, h_back, v_front, v_back;
    logic [6:0]  h_sync_m1, v_sync_m1;
    logic [1:0]  data_setup, data_hold;
    logic [4:0]  pol_sel;
    logic [15:0] rgb_in;
    logic        hsync_o, vsync_o, de_o, dclk_o, cs_o;
    logic [15:0] rgb_o;
    logic [9:0]  h_coord_o, v_coord_o;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string coord_tag = "R7";

    always #10 clk = ~clk;

    tft_sync_gen u0 (
        .clk(clk), .rst_n(rst_n), .drive_en(drive_en),
        .dclk_period(dclk_period), .start_pos(start_pos),
        .h_size_m1(h_size_m1), .v_size_m1(v_size_m1),
        .h_front(h_front), .h_back(h_back), .v_front(v_front), .v_back(v_back),
        .h_sync_m1(h_sync_m1), .v_sync_m1(v_sync_m1),
        .data_setup(data_setup), .data_hold(data_hold),
        .pol_sel(pol_sel), .rgb_in(rgb_in),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .dclk_o(dclk_o),
        .cs_o(cs_o), .rgb_o(rgb_o), .h_coord_o(h_coord_o), .v_coord_o(v_coord_o)
    );

    task automatic chk(string tag, string what, longint act, longint exp, int k);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, k, act, exp);
        end
    endtask

    function automatic bit pinv(bit active, int idx);
        return active ? pol_sel[idx] : !pol_sel[idx];
    endfunction

    // Pins with nothing active (R1, R10); chip select given separately
    task automatic chk_idle(string tag, bit cs_act, int k);
        chk(tag, "hsync", hsync_o, pinv(0, 0), k);
        chk(tag, "vsync", vsync_o, pinv(0, 1), k);
        chk(tag, "de", de_o, pinv(0, 2), k);
        chk(tag, "dclk", dclk_o, pinv(0, 3), k);
        chk((tag == "R3") ? "R3" : "R9", "cs", cs_o, pinv(cs_act, 4), k);
        chk(tag, "rgb", rgb_o, 0, k);
        chk(tag, "hcoord", h_coord_o, 0, k);
        chk(tag, "vcoord", v_coord_o, 0, k);
    endtask

    // Expected pins k rising edges after the enable was first sampled
    task automatic compare(int k);
        int p, hf, t, ph, n, h, v;
        int hs0, ha0, ha1, htot, vs0, va0, va1, vtot;
        bit hin, vin, dea, win;
        if (k < int'(start_pos)) begin
            chk_idle("R3", 1'b1, k);
            return;
        end
        p   = (dclk_period < 2) ? 2 : int'(dclk_period);
        hf  = p / 2;
        t   = k - int'(start_pos);
        ph  = t % p;
        n   = t / p;
        hs0 = int'(h_sync_m1) + 1;
        ha0 = hs0 + int'(h_back);
        ha1 = ha0 + int'(h_size_m1) + 1;
        htot = ha1 + int'(h_front);
        vs0 = int'(v_sync_m1) + 1;
        va0 = vs0 + int'(v_back);
        va1 = va0 + int'(v_size_m1) + 1;
        vtot = va1 + int'(v_front);
        h   = n % htot;
        v   = (n / htot) % vtot;
        hin = (h >= ha0) && (h < ha1);
        vin = (v >= va0) && (v < va1);
        dea = hin && vin;
        win = (ph + int'(data_setup) >= hf) && (ph <= hf + int'(data_hold));
        chk("R2", "dclk", dclk_o, pinv(ph >= hf, 3), k);
        chk("R4", "hsync", hsync_o, pinv(h < hs0, 0), k);
        chk("R5", "vsync", vsync_o, pinv(v < vs0, 1), k);
        chk("R6", "de", de_o, pinv(dea, 2), k);
        chk("R9", "cs", cs_o, pinv(1'b1, 4), k);
        chk(coord_tag, "hcoord", h_coord_o, dea ? h - ha0 : 0, k);
        chk(coord_tag, "vcoord", v_coord_o, dea ? v - va0 : 0, k);
        chk("R8", "rgb", rgb_o, (dea && win) ? rgb_in : 16'h0, k);
    endtask

    // Enable, follow ncyc edges, then disable and check the idle pins (R10)
    task automatic run_cfg(int ncyc);
        drive_en = 1'b1;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            compare(k);
        end
        drive_en = 1'b0;
        @(negedge clk);
        chk_idle("R10", 1'b0, -1);
    endtask

    task automatic set_cfg(int hs, int vs, int hfp, int hbp, int vfp, int vbp,
                           int hw, int vw, int per, int st, int su, int ho,
                           logic [4:0] pl, logic [15:0] px);
        h_size_m1 = 10'(hs - 1);  v_size_m1 = 10'(vs - 1);
        h_front = 8'(hfp); h_back = 8'(hbp); v_front = 8'(vfp); v_back = 8'(vbp);
        h_sync_m1 = 7'(hw - 1);   v_sync_m1 = 7'(vw - 1);
        dclk_period = 11'(per);   start_pos = 11'(st);
        data_setup = 2'(su);      data_hold = 2'(ho);
        pol_sel = pl;             rgb_in = px;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_7F71));
        rst_n = 1'b0;
        drive_en = 1'b0;
        set_cfg(3, 2, 1, 1, 1, 1, 1, 1, 4, 0, 1, 1, 5'b00000, 16'hA5A5);
        repeat (3) @(negedge clk);
        chk_idle("R1", 1'b0, -1);
        pol_sel = 5'b11111;
        #1;
        chk_idle("R1", 1'b0, -1);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: basic active-high layout, then re-enable restart (R10)
        run_cfg(400);
        run_cfg(200);
        // Periods 0 and 1 saturate to 2, window wider than the period (R2, R8)
        set_cfg(2, 2, 0, 0, 0, 0, 1, 1, 0, 0, 3, 3, 5'b01010, 16'h1234);
        run_cfg(120);
        set_cfg(2, 1, 1, 0, 1, 0, 2, 1, 1, 3, 0, 0, 5'b10101, 16'hBEEF);
        run_cfg(120);
        // Odd period, long start delay, mixed polarity (R3, R9)
        set_cfg(4, 3, 2, 1, 1, 2, 3, 2, 9, 7, 2, 1, 5'b00110, 16'h0F0F);
        run_cfg(1200);
        // Full 1024-pixel line with zero porches (R11)
        coord_tag = "R11";
        set_cfg(1024, 1, 0, 0, 0, 0, 1, 1, 2, 0, 0, 0, 5'b11111, 16'hFFFF);
        run_cfg(4200);
        coord_tag = "R7";

        for (int r = 0; r < 30; r++) begin
            set_cfg($urandom_range(1, 6), $urandom_range(1, 4),
                    $urandom_range(0, 3), $urandom_range(0, 3),
                    $urandom_range(0, 2), $urandom_range(0, 2),
                    $urandom_range(1, 3), $urandom_range(1, 2),
                    $urandom_range(0, 7), $urandom_range(0, 4),
                    $urandom_range(0, 3), $urandom_range(0, 3),
                    5'($urandom()), 16'($urandom_range(1, 65535)));
            run_cfg(1200);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule